// File: doc/BRIEF.md
# String Load Register Packing Sequencer

This block executes an indexed string load on behalf of a processor pipeline. When started, it forms an effective address from a base register operand and an index register operand. It takes the transfer length from a 7-bit byte-count field. It then reads that many bytes, one at a time, through a byte-wide read port that uses a valid/ready request and a separate response. The bytes are packed big-endian into 32-bit words, and each word is written to the register file through a single write port.

Destination register numbers start at the target number and wrap from 31 back to 0. The register named as the base operand and the register named as the index operand are never overwritten unless one of them is the final register of the sequence. The pipeline starts an operation with a one-cycle start pulse. It sees busy while bytes are moving, and a one-cycle done pulse at the end.

Top module: `strld_seq`

## Requirements
- R1: The first byte is read from address (base number == 0 ? 0 : base value) + index value, taken modulo 2^32. Byte k of the string is read from that address plus k.
- R2: The byte count n is sampled from `byte_cnt_i` when start is accepted. Exactly n read requests are issued, in increasing address order.
- R3: Byte k is written to register (target + k/4) mod 32, in bit lane [31-8*(k%4) -: 8]. The first byte of a word is most significant.
- R4: In a final word with fewer than 4 bytes, the unfilled low-order byte lanes are written as zero.
- R5: Register numbering wraps modulo 32, so register 0 follows register 31. The final register is (target + ceil(n/4) - 1) mod 32.
- R6: A word whose register number equals the captured base number or the captured index number is not written, unless it is the final register. This holds when the base number is 0 too.
- R7: With n = 0, no read request and no register write is made. `done_o` is high in the cycle after start is accepted.
- R8: At most one byte read is outstanding. A request holds `mem_req_valid_o` and a stable address until `mem_req_ready_i`. No new request is issued until the response arrives.
- R9: Start is accepted only when neither busy nor done. `busy_o` is high from the cycle after an accepted start (when n > 0) until done. `done_o` is a one-cycle pulse that coincides with the last write. Register writes occur only while busy or done.
- R10: The register numbers, operand values and count are captured at start. Changes on those inputs during a sequence have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| rt_i | input | 5 | First destination register number |
| ra_i | input | 5 | Base register number |
| rb_i | input | 5 | Index register number |
| ra_val_i | input | 32 | Base register value |
| rb_val_i | input | 32 | Index register value |
| byte_cnt_i | input | 7 | Byte count field |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_valid_o | output | 1 | Byte read request valid |
| mem_req_ready_i | input | 1 | Byte read request accepted |
| mem_addr_o | output | 32 | Byte read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 8 | Read data byte |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write number |
| rf_wdata_o | output | 32 | Register write data |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted request. They also assume that this response arrives in a later cycle than the acceptance, and never without a pending request. The bench memory model keeps within this. It records each handshake and raises a single response after zero to two idle cycles. It drives `mem_req_ready_i` at random, so that both held requests and immediate acceptance occur. Start pulses are issued only from idle, except for one deliberate pulse while busy, which the design must ignore.

// File: rtl/strld_pkg.sv
package strld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } strld_state_e;
endpackage

// File: rtl/strld_ea.sv
// Effective address former: a base number of zero contributes zero.
module strld_ea #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] base_num_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [ADDR_W-1:0] index_val_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] base_term;

  always_comb begin
    base_term = (base_num_i == '0) ? '0 : base_val_i;
    ea_o      = base_term + index_val_i;
  end
endmodule

// File: rtl/strld_pack.sv
// Big-endian byte packer: lane 0 is the most significant byte.
module strld_pack #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  // A byte in lane 0 opens a new word, so the other lanes restart at zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = DATA_W - 1 - g * BYTE_W;
    always_comb begin
      if (lane_i == LANE_W'(g)) begin
        word_d[HI -: BYTE_W] = byte_i;
      end else if (lane_i == '0) begin
        word_d[HI -: BYTE_W] = '0;
      end else begin
        word_d[HI -: BYTE_W] = word_q[HI -: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (byte_vld_i) begin
      word_q <= word_d;
    end
  end

  assign word_o = word_d;
endmodule

// File: rtl/strld_regidx.sv
// Destination register tracking: wrap-around, final register, base/index guard.
module strld_regidx #(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 7,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [REG_AW-1:0] rt_i,
  input  logic [REG_AW-1:0] ra_i,
  input  logic [REG_AW-1:0] rb_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              adv_i,
  output logic [REG_AW-1:0] cur_o,
  output logic              keep_o
);
  logic [REG_AW-1:0] cur_q, final_q, ra_q, rb_q;
  logic [REG_AW-1:0] cur_d, final_d;
  logic [CNT_W-1:0]  cnt_m1;

  always_comb begin
    cnt_m1  = cnt_i - 1'b1;
    final_d = rt_i + REG_AW'(cnt_m1 >> LANE_W);
    if (load_i) begin
      cur_d = rt_i;
    end else if (adv_i) begin
      cur_d = cur_q + 1'b1;
    end else begin
      cur_d = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      final_q <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
    end else begin
      cur_q <= cur_d;
      if (load_i) begin
        final_q <= final_d;
        ra_q    <= ra_i;
        rb_q    <= rb_i;
      end
    end
  end

  assign cur_o  = cur_q;
  assign keep_o = (cur_q == final_q) || ((cur_q != ra_q) && (cur_q != rb_q));
endmodule

// File: rtl/strld_seq.sv
module strld_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int REG_AW = 5,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [REG_AW-1:0] rt_i,
  input  logic [REG_AW-1:0] ra_i,
  input  logic [REG_AW-1:0] rb_i,
  input  logic [ADDR_W-1:0] ra_val_i,
  input  logic [ADDR_W-1:0] rb_val_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BYTE_W-1:0] mem_rsp_data_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o
);
  import strld_pkg::*;

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  strld_state_e      state_q, state_d;
  logic [ADDR_W-1:0] ea_q, ea_w;
  logic [CNT_W-1:0]  n_q, idx_q, idx_d, idx_inc;
  logic              we_q;
  logic [REG_AW-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  logic              start_acc, req_hs, rsp_acc, last_byte, word_done;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] word;
  logic [REG_AW-1:0] cur_reg;
  logic              keep;

  strld_ea #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_ea (
    .base_num_i (ra_i),
    .base_val_i (ra_val_i),
    .index_val_i(rb_val_i),
    .ea_o       (ea_w)
  );

  strld_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_ns),
    .byte_vld_i(rsp_acc),
    .lane_i    (lane),
    .byte_i    (mem_rsp_data_i),
    .word_o    (word)
  );

  strld_regidx #(.REG_AW(REG_AW), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_regidx (
    .clk   (clk),
    .rst_n (rst_ns),
    .load_i(start_acc),
    .rt_i  (rt_i),
    .ra_i  (ra_i),
    .rb_i  (rb_i),
    .cnt_i (byte_cnt_i),
    .adv_i (word_done),
    .cur_o (cur_reg),
    .keep_o(keep)
  );

  always_comb begin
    start_acc = (state_q == ST_IDLE) && start_i;
    req_hs    = (state_q == ST_REQ) && mem_req_ready_i;
    rsp_acc   = (state_q == ST_WAIT) && mem_rsp_valid_i;
    lane      = idx_q[LANE_W-1:0];
    idx_inc   = idx_q + 1'b1;
    last_byte = (idx_inc == n_q);
    word_done = rsp_acc && ((lane == {LANE_W{1'b1}}) || last_byte);

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_acc) state_d = (byte_cnt_i == '0) ? ST_DONE : ST_REQ;
      ST_REQ:  if (req_hs)    state_d = ST_WAIT;
      ST_WAIT: if (rsp_acc)   state_d = last_byte ? ST_DONE : ST_REQ;
      ST_DONE:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase

    if (start_acc) begin
      idx_d = '0;
    end else if (rsp_acc) begin
      idx_d = idx_inc;
    end else begin
      idx_d = idx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      n_q     <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      we_q    <= word_done && keep;
      if (start_acc) begin
        ea_q <= ea_w;
        n_q  <= byte_cnt_i;
      end
      if (word_done) begin
        waddr_q <= cur_reg;
        wdata_q <= word;
      end
    end
  end

  assign busy_o          = (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign done_o          = (state_q == ST_DONE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_addr_o      = ea_q + ADDR_W'(idx_q);
  assign rf_we_o         = we_q;
  assign rf_waddr_o      = waddr_q;
  assign rf_wdata_o      = wdata_q;
endmodule

// File: rtl/strld_seq_chk.sv
module strld_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CNT_W-1:0]  byte_cnt_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              rf_we_o
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      pending_q <= 1'b1;
    end else if (mem_rsp_valid_i) begin
      pending_q <= 1'b0;
    end
  end

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !mem_req_valid_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_valid_o);

  p_write_in_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (busy_o || done_o));

  p_empty_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o && (byte_cnt_i == '0)) |=> (done_o && !rf_we_o && !mem_req_valid_o));
endmodule

bind strld_seq strld_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_ns),
  .start_i        (start_i),
  .byte_cnt_i     (byte_cnt_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_addr_o     (mem_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .rf_we_o        (rf_we_o)
);

// File: tb/test_strld_seq.sv
module test_strld_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  rt_i = '0, ra_i = '0, rb_i = '0;
  logic [31:0] ra_val_i = '0, rb_val_i = '0;
  logic [6:0]  byte_cnt_i = '0;
  logic        busy_o, done_o, mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [7:0]  mem_rsp_data_i = '0;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  strld_seq i_strld_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rt_i(rt_i), .ra_i(ra_i), .rb_i(rb_i),
    .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .byte_cnt_i(byte_cnt_i),
    .busy_o(busy_o), .done_o(done_o), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_addr_o(mem_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[31:24] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] exp_addr[$];
  logic [36:0] exp_wr[$];   // {register number, data}

  // Memory model: one response per accepted request, 0..2 idle cycles later.
  bit          hs_next = 0, pend = 0;
  int          dly = 0;
  logic [31:0] paddr = '0;
  always @(negedge clk) begin
    mem_rsp_valid_i = 1'b0;
    if (hs_next) begin
      pend = 1; dly = $urandom_range(0, 2); hs_next = 0;
    end else if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = mem_byte(paddr); pend = 0;
      end else dly--;
    end
    mem_req_ready_i = rst_n && ($urandom_range(0, 3) != 0);
    if (mem_req_valid_o && mem_req_ready_i) begin
      hs_next = 1; paddr = mem_addr_o;
      // R1 R2: address order and count
      if (exp_addr.size() == 0) chk(0, "R2 extra read request", {32'd0, mem_addr_o}, 64'd0);
      else begin
        logic [31:0] ea;
        ea = exp_addr.pop_front();
        chk(mem_addr_o == ea, "R1 R2 read address", {32'd0, mem_addr_o}, {32'd0, ea});
      end
    end
  end

  // Monitor: register writes against the scoreboard (R3 R4 R5 R6)
  always @(negedge clk) begin
    if (rst_n && rf_we_o) begin
      if (exp_wr.size() == 0) chk(0, "R6 R7 unexpected write", {27'd0, rf_waddr_o, rf_wdata_o}, 64'd0);
      else begin
        logic [36:0] w;
        w = exp_wr.pop_front();
        chk({rf_waddr_o, rf_wdata_o} == w, "R3 R4 R5 R6 write num/data",
            {27'd0, rf_waddr_o, rf_wdata_o}, {27'd0, w});
      end
    end
  end

  task automatic run_case(input logic [4:0] rt, input logic [4:0] ra, input logic [4:0] rb,
                          input logic [31:0] rav, input logic [31:0] rbv, input int n,
                          input bit poke_busy);
    logic [31:0] ea;
    int nw;
    ea = ((ra == 0) ? 32'd0 : rav) + rbv;
    nw = (n + 3) / 4;
    for (int k = 0; k < n; k++) exp_addr.push_back(ea + 32'(k));
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      logic [4:0]  r;
      d = '0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < n) d[31 - 8 * b -: 8] = mem_byte(ea + 32'(4 * w + b));
      r = rt + 5'(w);
      if (w == nw - 1 || (r != ra && r != rb)) exp_wr.push_back({r, d});
    end
    @(negedge clk);
    rt_i = rt; ra_i = ra; rb_i = rb; ra_val_i = rav; rb_val_i = rbv;
    byte_cnt_i = 7'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble operands once captured
    ra_val_i = ~rav; rb_val_i = rbv + 32'h1234; byte_cnt_i = 7'(n + 5); rt_i = rt + 5'd9;
    if (n == 0) chk(done_o && !busy_o, "R7 done next cycle", {62'd0, busy_o, done_o}, 64'd1);
    else        chk(busy_o && !done_o, "R9 busy after start", {62'd0, busy_o, done_o}, 64'd2);
    if (poke_busy) begin
      start_i = 1'b1; byte_cnt_i = 7'd3; rt_i = 5'd17;   // R9: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int t = 0; t < 3000 && !done_o; t++) @(negedge clk);
    chk(done_o, "R9 done reached", {63'd0, done_o}, 64'd1);
    @(negedge clk);
    chk(!done_o && !busy_o, "R9 done single pulse", {62'd0, busy_o, done_o}, 64'd0);
    chk(exp_addr.size() == 0, "R2 all bytes read", 64'(exp_addr.size()), 64'd0);
    chk(exp_wr.size() == 0, "R3 R5 all words written", 64'(exp_wr.size()), 64'd0);
    exp_addr.delete(); exp_wr.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_valid_o && !rf_we_o, "R9 reset state",
        {60'd0, busy_o, done_o, mem_req_valid_o, rf_we_o}, 64'd0);
    // R3 R4: three words, last holds one byte
    run_case(5'd3, 5'd10, 5'd11, 32'h0000_1000, 32'h0000_0021, 9, 1'b1);
    // R1 R5 R6: base number 0, wrap 30..1, index reg 31 and reg 0 suppressed
    run_case(5'd30, 5'd0, 5'd31, 32'hDEAD_BEEF, 32'h0000_4400, 16, 1'b0);
    // R6: base reg suppressed, index reg is final and written
    run_case(5'd5, 5'd5, 5'd6, 32'h0001_0000, 32'h0000_0203, 8, 1'b1);
    // R7: empty transfer
    run_case(5'd7, 5'd1, 5'd2, 32'h10, 32'h20, 0, 1'b0);
    // R2 R5 R1: maximum count, address wraps past 2^32
    run_case(5'd0, 5'd2, 5'd20, 32'h0000_0008, 32'hFFFF_FFE8, 127, 1'b1);
    // R4: single byte, and an exact word
    run_case(5'd31, 5'd4, 5'd4, 32'h0000_0300, 32'h0000_0007, 1, 1'b0);
    run_case(5'd12, 5'd12, 5'd13, 32'h0000_7000, 32'h0000_0011, 4, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule